// File: doc/BRIEF.md
# Inter-Thread Address Pattern Classifier

This block looks at the addresses that a group of threads issue together for one load or store and decides how regular they are. When every thread targets the same location the access is uniform. When the addresses follow `base + stride * thread_id` exactly, with one stride and one base shared by the whole group, the access is affine. Anything else is scattered. For an affine access the block also reports the stride and the base. It flags the access as contiguous when the stride equals the configured word size, and it reports how many memory transactions the access needs.

The base is the address of thread 0 and the stride is the address of thread 1 minus the address of thread 0. Every other thread is checked against that line in modular two's-complement arithmetic, so negative strides and address wrap-around are handled. A result is produced only when every thread in the group is active. Otherwise the access is reported as not counted. When the group has only two threads, an affine fit is always possible, so no access is ever called affine and every non-uniform access is scattered. The block has two register stages: one captures the inputs and one holds the result.

Top module: `addr_pattern_classifier`

## Requirements
- R1: With all threads active and all addresses equal, the class is uniform (code 0) and the transaction count is 1.
- R2: With all threads active, more than two threads, unequal addresses and every address equal to `a0 + (a1 - a0) * id` modulo 2^ADDR_W, the class is affine (code 1). The stride output is `a1 - a0` and the base output is `a0`.
- R3: With all threads active and addresses that are neither uniform nor affine, the class is scattered (code 2). The transaction count equals the thread count, and the contiguous flag is 0.
- R4: When the thread count parameter is 2, any non-uniform access with both threads active is scattered (code 2) with a transaction count of 2. It is never affine.
- R5: An affine access whose stride equals `cfg_word_bytes` sets the contiguous flag and reports a transaction count of 1.
- R6: An affine access whose stride differs from `cfg_word_bytes` clears the contiguous flag and reports a transaction count equal to the thread count.
- R7: If any bit of `in_active` is 0, the class is not-counted (code 3). Transaction count, contiguous flag, stride and base are all 0.
- R8: Strides are treated as signed modular values. A negative stride, or a line of addresses that wraps past the top of the address space, is still classified as affine.
- R9: Each access pulses `out_valid` for one cycle, two clock edges after the edge that samples `in_valid`. Accesses on back-to-back cycles give results on back-to-back cycles, in order. Reset clears `out_valid` and sets the class to not-counted with zero count.
- R10: For every class other than affine, the stride and base outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An access is presented this cycle |
| in_active | input | N_THR | Per-thread active mask, bit i is thread i |
| in_addr | input | N_THR*ADDR_W | Thread i address in bits [i*ADDR_W +: ADDR_W] |
| cfg_word_bytes | input | ADDR_W | Word size used for the contiguity test |
| out_valid | output | 1 | Result strobe |
| out_class | output | 2 | 0 uniform, 1 affine, 2 scattered, 3 not counted |
| out_stride | output | ADDR_W | Affine stride (two's complement) |
| out_base | output | ADDR_W | Affine base (thread 0 address) |
| out_contig | output | 1 | Affine with stride equal to the word size |
| out_txn | output | $clog2(N_THR+1) | Memory transactions needed |

## Verification
The four-thread instance is driven with several address patterns. Identical addresses separate uniform from affine with a zero stride. Word-spaced lines and wide-spaced lines separate contiguous from non-contiguous affine accesses. A negative stride and a line that wraps around zero exercise the signed modular fit. A pattern in which only the last thread breaks the line separates scattered from affine. A partial mask over otherwise uniform addresses shows that the not-counted rule overrides every other outcome. A second, two-thread instance shows that unequal pairs fall to scattered and never to affine. Back-to-back issue checks that results keep their order and their two-cycle latency.

// File: rtl/apc_pkg.sv
package apc_pkg;
   typedef enum logic [1:0] {
      ACC_UNIFORM = 2'd0,
      ACC_AFFINE  = 2'd1,
      ACC_SCATTER = 2'd2,
      ACC_SKIPPED = 2'd3
   } acc_class_e;
endpackage

// File: rtl/apc_capture.sv
// Input stage: samples one access and reduces the active mask.
module apc_capture #(
   parameter int N_THR  = 4,
   parameter int ADDR_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [N_THR-1:0]          in_active,
   input  logic [N_THR*ADDR_W-1:0]   in_addr,
   input  logic [ADDR_W-1:0]         in_word,
   output logic                      s_valid,
   output logic                      s_full,
   output logic [N_THR*ADDR_W-1:0]   s_addr,
   output logic [ADDR_W-1:0]         s_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= 1'b0;
         s_full  <= 1'b0;
         s_addr  <= '0;
         s_word  <= '0;
      end else begin
         s_valid <= in_valid;
         if (in_valid) begin
            s_full <= &in_active;
            s_addr <= in_addr;
            s_word <= in_word;
         end
      end
   end
endmodule

// File: rtl/apc_lane.sv
// One thread lane: is its address on the line, and is it equal to the base?
module apc_lane #(
   parameter int ADDR_W  = 32,
   parameter int LANE_ID = 0
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [ADDR_W-1:0] addr,
   output logic              eq_base,
   output logic              on_line
);
   localparam logic [ADDR_W-1:0] LANE_K = ADDR_W'(LANE_ID);
   logic [ADDR_W-1:0] expect_addr;

   always_comb begin
      expect_addr = base + (stride * LANE_K);
      eq_base     = (addr == base);
      on_line     = (addr == expect_addr);
   end
endmodule

// File: rtl/apc_decide.sv
// Combines lane votes into class, stride, base, contiguity and count.
module apc_decide
   import apc_pkg::*;
#(
   parameter int N_THR  = 4,
   parameter int ADDR_W = 32,
   localparam int CNT_W = $clog2(N_THR + 1)
) (
   input  logic              full,
   input  logic [N_THR-1:0]  eq_base,
   input  logic [N_THR-1:0]  on_line,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [ADDR_W-1:0] word,
   output acc_class_e        d_class,
   output logic [ADDR_W-1:0] d_stride,
   output logic [ADDR_W-1:0] d_base,
   output logic              d_contig,
   output logic [CNT_W-1:0]  d_txn
);
   localparam logic [CNT_W-1:0] ALL_TXN = CNT_W'(N_THR);
   logic affine_ok;

   generate
      if (N_THR == 2) begin : g_pair
         // with two threads any pair fits a line, so no affine class
         assign affine_ok = 1'b0;
      end else begin : g_wide
         assign affine_ok = &on_line;
      end
   endgenerate

   always_comb begin
      d_class  = ACC_SKIPPED;
      d_stride = '0;
      d_base   = '0;
      d_contig = 1'b0;
      d_txn    = '0;
      if (full) begin
         if (&eq_base) begin
            d_class = ACC_UNIFORM;
            d_txn   = CNT_W'(1);
         end else if (affine_ok) begin
            d_class  = ACC_AFFINE;
            d_stride = stride;
            d_base   = base;
            d_contig = (stride == word);
            d_txn    = (stride == word) ? CNT_W'(1) : ALL_TXN;
         end else begin
            d_class = ACC_SCATTER;
            d_txn   = ALL_TXN;
         end
      end
   end
endmodule

// File: rtl/addr_pattern_classifier.sv
module addr_pattern_classifier
   import apc_pkg::*;
#(
   parameter int N_THR  = 4,
   parameter int ADDR_W = 32,
   localparam int CNT_W = $clog2(N_THR + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [N_THR-1:0]         in_active,
   input  logic [N_THR*ADDR_W-1:0]  in_addr,
   input  logic [ADDR_W-1:0]        cfg_word_bytes,
   output logic                     out_valid,
   output logic [1:0]               out_class,
   output logic [ADDR_W-1:0]        out_stride,
   output logic [ADDR_W-1:0]        out_base,
   output logic                     out_contig,
   output logic [CNT_W-1:0]         out_txn
);
   generate
      if (N_THR < 2) begin : g_bad_n
         $error("N_THR must be at least 2");
      end
      if (ADDR_W < 2) begin : g_bad_w
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic                    s_valid, s_full;
   logic [N_THR*ADDR_W-1:0] s_addr;
   logic [ADDR_W-1:0]       s_word, s_base, s_stride;
   logic [N_THR-1:0]        eq_base, on_line;
   acc_class_e              d_class;
   logic [ADDR_W-1:0]       d_stride, d_base;
   logic                    d_contig;
   logic [CNT_W-1:0]        d_txn;

   apc_capture #(.N_THR(N_THR), .ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_active(in_active),
      .in_addr(in_addr), .in_word(cfg_word_bytes),
      .s_valid(s_valid), .s_full(s_full), .s_addr(s_addr), .s_word(s_word)
   );

   assign s_base   = s_addr[0 +: ADDR_W];
   assign s_stride = s_addr[ADDR_W +: ADDR_W] - s_base;

   for (genvar i = 0; i < N_THR; i++) begin : g_lane
      apc_lane #(.ADDR_W(ADDR_W), .LANE_ID(i)) u_lane (
         .base(s_base), .stride(s_stride), .addr(s_addr[i*ADDR_W +: ADDR_W]),
         .eq_base(eq_base[i]), .on_line(on_line[i])
      );
   end

   apc_decide #(.N_THR(N_THR), .ADDR_W(ADDR_W)) u_dec (
      .full(s_full), .eq_base(eq_base), .on_line(on_line),
      .base(s_base), .stride(s_stride), .word(s_word),
      .d_class(d_class), .d_stride(d_stride), .d_base(d_base),
      .d_contig(d_contig), .d_txn(d_txn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_class  <= ACC_SKIPPED;
         out_stride <= '0;
         out_base   <= '0;
         out_contig <= 1'b0;
         out_txn    <= '0;
      end else begin
         out_valid <= s_valid;
         if (s_valid) begin
            out_class  <= d_class;
            out_stride <= d_stride;
            out_base   <= d_base;
            out_contig <= d_contig;
            out_txn    <= d_txn;
         end
      end
   end

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);
   // R1
   uniform_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_class == ACC_UNIFORM) |-> (out_txn == CNT_W'(1) && !out_contig));
   // R7
   skipped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_class == ACC_SKIPPED) |-> (out_txn == '0 && !out_contig));
   // R5
   contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_contig) |-> (out_class == ACC_AFFINE && out_txn == CNT_W'(1)));
   // R10
   nonaffine_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_class != ACC_AFFINE) |-> (out_stride == '0 && out_base == '0));
   // R7
   partial_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(&in_active)) |-> ##2 (out_class == ACC_SKIPPED));

   generate
      if (N_THR == 2) begin : g_pair_chk
         // R4
         pair_no_affine_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_class != ACC_AFFINE);
      end
   endgenerate
endmodule

// File: tb/sim_addr_pattern_classifier.sv
`timescale 1ns/1ps
module sim_addr_pattern_classifier;
   localparam int N = 4;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic           in_valid = 1'b0;
   logic [N-1:0]   in_active = '0;
   logic [N*W-1:0] in_addr = '0;
   logic [W-1:0]   cfg_word = '0;
   logic           out_valid;
   logic [1:0]     out_class;
   logic [W-1:0]   out_stride, out_base;
   logic           out_contig;
   logic [2:0]     out_txn;

   addr_pattern_classifier #(.N_THR(N), .ADDR_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_active(in_active),
      .in_addr(in_addr), .cfg_word_bytes(cfg_word),
      .out_valid(out_valid), .out_class(out_class), .out_stride(out_stride),
      .out_base(out_base), .out_contig(out_contig), .out_txn(out_txn)
   );

   // two-thread instance
   logic           p_valid = 1'b0;
   logic [1:0]     p_active = '0;
   logic [2*W-1:0] p_addr = '0;
   logic           p_ovalid, p_contig;
   logic [1:0]     p_class, p_txn;
   logic [W-1:0]   p_stride, p_base;

   addr_pattern_classifier #(.N_THR(2), .ADDR_W(W)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(p_valid), .in_active(p_active),
      .in_addr(p_addr), .cfg_word_bytes(32'd4),
      .out_valid(p_ovalid), .out_class(p_class), .out_stride(p_stride),
      .out_base(p_base), .out_contig(p_contig), .out_txn(p_txn)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      logic [1:0]   cls;
      logic [W-1:0] stride;
      logic [W-1:0] base;
      logic         contig;
      logic [2:0]   txn;
      int           due;
   } exp_t;
   exp_t  sb_q[$];
   string tag_q[$];

   // reference model written from the requirements
   function automatic exp_t model(input logic [N-1:0] act,
                                  input logic [W-1:0] a [N],
                                  input logic [W-1:0] w);
      exp_t e;
      logic uni, aff;
      logic [W-1:0] st;
      e.cls = 2'd3; e.stride = '0; e.base = '0; e.contig = 1'b0; e.txn = '0; e.due = 0;
      if (&act) begin
         st = a[1] - a[0];
         uni = 1'b1; aff = 1'b1;
         for (int i = 0; i < N; i++) begin
            if (a[i] != a[0]) uni = 1'b0;
            if (a[i] != a[0] + st * W'(i)) aff = 1'b0;
         end
         if (uni) begin
            e.cls = 2'd0; e.txn = 3'd1;
         end else if (aff && N > 2) begin
            e.cls = 2'd1; e.stride = st; e.base = a[0];
            e.contig = (st == w);
            e.txn = (st == w) ? 3'd1 : 3'(N);
         end else begin
            e.cls = 2'd2; e.txn = 3'(N);
         end
      end
      return e;
   endfunction

   task automatic send(input string tag, input logic [N-1:0] act,
                       input logic [W-1:0] a0, input logic [W-1:0] a1,
                       input logic [W-1:0] a2, input logic [W-1:0] a3,
                       input logic [W-1:0] w);
      logic [W-1:0] a [N];
      exp_t e;
      a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
      @(negedge clk);
      in_valid  = 1'b1;
      in_active = act;
      in_addr   = {a3, a2, a1, a0};
      cfg_word  = w;
      e = model(act, a, w);
      e.due = cyc + 2;
      sb_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R9 unexpected out_valid: actual 1 expected 0");
         end else begin
            exp_t e;
            string t;
            e = sb_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "class", W'(out_class), W'(e.cls));
            chk(t, "stride", out_stride, e.stride);
            chk(t, "base", out_base, e.base);
            chk(t, "contig", W'(out_contig), W'(e.contig));
            chk(t, "txn", W'(out_txn), W'(e.txn));
            chk("R9", "latency", W'(cyc), W'(e.due));
         end
      end
   end

   task automatic pair(input string tag, input logic [W-1:0] a0, input logic [W-1:0] a1,
                       input logic [1:0] ecls, input logic [1:0] etxn);
      @(negedge clk);
      p_valid = 1'b1; p_active = 2'b11; p_addr = {a1, a0};
      @(negedge clk);
      p_valid = 1'b0;
      @(negedge clk);
      chk(tag, "pair valid", W'(p_ovalid), W'(1));
      chk(tag, "pair class", W'(p_class), W'(ecls));
      chk(tag, "pair txn", W'(p_txn), W'(etxn));
      chk(tag, "pair stride", p_stride, '0);
   endtask

   logic done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "reset valid", W'(out_valid), W'(0));
      chk("R9", "reset class", W'(out_class), W'(3));
      chk("R9", "reset txn", W'(out_txn), W'(0));
      rst_n = 1'b1;
      idle(2);
      // R1 uniform
      send("R1", 4'hF, 32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'd4);
      idle(1);
      // R2 R5 contiguous affine
      send("R5", 4'hF, 32'h2000, 32'h2004, 32'h2008, 32'h200C, 32'd4);
      // R2 R6 wide stride, back-to-back
      send("R6", 4'hF, 32'h0100, 32'h0140, 32'h0180, 32'h01C0, 32'd4);
      // R8 negative stride
      send("R8", 4'hF, 32'h0500, 32'h04F8, 32'h04F0, 32'h04E8, 32'd8);
      // R3 only last thread off the line
      send("R3", 4'hF, 32'h0000, 32'h0004, 32'h0008, 32'h000D, 32'd4);
      // R7 partial mask over uniform addresses
      send("R7", 4'b1011, 32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'd4);
      // R6 stride 4 against word 8
      send("R6", 4'hF, 32'h3000, 32'h3004, 32'h3008, 32'h300C, 32'd8);
      // R8 wrap past top of address space
      send("R8", 4'hF, 32'hFFFF_FFF8, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0004, 32'd4);
      // R10 scattered with distinct values
      send("R10", 4'hF, 32'h10, 32'h90, 32'h20, 32'h40, 32'd4);
      // R2 affine with unusual base
      send("R2", 4'hF, 32'h7777, 32'h7787, 32'h7797, 32'h77A7, 32'd4);
      idle(4);
      chk("R9", "queue drained", W'(sb_q.size()), W'(0));
      // R4 two-thread instance
      pair("R4", 32'h40, 32'h44, 2'd2, 2'd2);
      pair("R1", 32'h80, 32'h80, 2'd0, 2'd1);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule